// File: doc/BRIEF.md
# Receiver Standby and Wakeup Controller

This block sits beside a serial receiver on a multi-drop line and decides which received characters reach the data path. Software sets a standby request when the traffic on the line is meant for another node. While in standby, completed characters are held back: the data-full and error flags never see them. The block then watches for a wakeup condition. That condition is either an idle line or a character carrying an address mark, and a configuration input picks which one. When the condition is met, the block clears standby by itself.

The block also produces the idle-line flag. An idle character is a run of consecutive high bit times as long as one frame: 10 bits, plus one for 9-bit data, plus one for a second stop bit. The run can be counted from the start bit onward, in which case high data and stop bits count. It can also be counted only from the end of the character. Once the flag has been raised, it is raised again only after a new character has been received. The flag can drive an interrupt request, and it can be held off while in standby.

Top module: `rx_standby_wake`

## Requirements
- R1: After reset, idle_flag, idle_irq and standby are 0.
- R2: Outside standby, idle_flag rises one clock after the bit_tick on which line_in has been high for L consecutive counted ticks, where L = 10 + nine_bit + two_stop. A tick with line_in low restarts the count.
- R3: With idle_type = 0, char_done does not disturb the count, so high data and stop bits count toward L. With idle_type = 1, char_done restarts the count, and a bit_tick in the same cycle is not counted.
- R4: After idle_flag has been set, a further idle run does not set it again until a char_done has been seen. A char_done in the same cycle as a completed idle run re-arms the flag.
- R5: idle_clr clears idle_flag on the next clock. A set in the same cycle wins over the clear.
- R6: idle_irq is high exactly when idle_flag and idle_ie are both 1.
- R7: sby_set makes standby 1 on the next clock, and sby_clr makes it 0. sby_set wins over sby_clr and over a wakeup in the same cycle.
- R8: With wake_sel = 0, a completed idle run while in standby pulses wake in that cycle and clears standby on the next clock. Characters finishing while in standby are not delivered. The next character is delivered.
- R9: With wake_sel = 1, a char_done with addr_mark = 1 while in standby pulses wake, is delivered in the same cycle, and clears standby. A char_done with addr_mark = 0 is not delivered. An idle run does not wake.
- R10: While in standby, a completed idle run sets idle_flag only if idle_in_sby = 1.
- R11: deliver is high only in a char_done cycle. Outside standby it equals char_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One pulse per bit time, at the bit sample point |
| line_in | input | 1 | Receive line level at the sample point (1 = mark/idle) |
| char_done | input | 1 | Strobe: a character has been completed |
| addr_mark | input | 1 | Most significant data bit of the completed character, valid with char_done |
| wake_sel | input | 1 | 0 = idle-line wakeup, 1 = address-mark wakeup |
| idle_type | input | 1 | 0 = idle count from start bit, 1 = from end of stop bit |
| idle_in_sby | input | 1 | 1 = idle flag may be set while in standby |
| idle_ie | input | 1 | Idle interrupt enable |
| nine_bit | input | 1 | 1 = 9-bit data frame |
| two_stop | input | 1 | 1 = two stop bits |
| sby_set | input | 1 | Strobe: enter standby |
| sby_clr | input | 1 | Strobe: leave standby |
| idle_clr | input | 1 | Strobe: clear the idle flag |
| idle_flag | output | 1 | Idle line detected |
| idle_irq | output | 1 | Idle interrupt request |
| standby | output | 1 | Receiver is in standby |
| deliver | output | 1 | Completed character may be handed to the data register and flags |
| wake | output | 1 | Wakeup condition met this cycle |

## Verification
Two functions can fall in the same clock. One is the bit tick that completes an idle run. The other is the character-done strobe, which either re-arms the flag or, with counting from the stop bit, restarts the count. The bench provokes this by issuing the final high tick of a run together with char_done, under both idle types. It then judges on the following clocks whether the flag rose and whether a later run can raise it again. A second collision pairs a standby request with a wakeup event in the same cycle, and standby must stay set.

// File: rtl/rx_standby_wake.sv
module rx_standby_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic line_in,
  input  logic char_done,
  input  logic addr_mark,
  input  logic wake_sel,
  input  logic idle_type,
  input  logic idle_in_sby,
  input  logic idle_ie,
  input  logic nine_bit,
  input  logic two_stop,
  input  logic sby_set,
  input  logic sby_clr,
  input  logic idle_clr,
  output logic idle_flag,
  output logic idle_irq,
  output logic standby,
  output logic deliver,
  output logic wake
);
  localparam int CW = 4;

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] frame_len;
  logic          armed;
  logic          restart;
  logic          idle_evt;
  logic          idle_set;

  assign frame_len = CW'(10) + CW'(nine_bit) + CW'(two_stop);
  assign restart   = idle_type & char_done;
  assign idle_evt  = bit_tick & line_in & ~restart & (run_cnt == frame_len - CW'(1));
  assign idle_set  = idle_evt & armed & (~standby | idle_in_sby);
  assign wake      = standby & (wake_sel ? (char_done & addr_mark) : idle_evt);
  assign deliver   = char_done & (~standby | (wake_sel & addr_mark));
  assign idle_irq  = idle_flag & idle_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (restart) begin
      run_cnt <= '0;
    end else if (bit_tick) begin
      if (!line_in)                 run_cnt <= '0;
      else if (run_cnt < frame_len) run_cnt <= run_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_flag <= 1'b0;
      armed     <= 1'b1;
    end else begin
      if (idle_set)      idle_flag <= 1'b1;
      else if (idle_clr) idle_flag <= 1'b0;
      if (char_done)     armed <= 1'b1;
      else if (idle_set) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 standby <= 1'b0;
    else if (sby_set)           standby <= 1'b1;
    else if (sby_clr || wake)   standby <= 1'b0;
  end

  assert_set_on_high_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> $past(bit_tick && line_in));

  assert_enter_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sby_set |=> standby);

  assert_mark_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && wake_sel && char_done && addr_mark && !sby_set) |=> !standby);

  assert_no_idle_in_sby_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !idle_in_sby && !idle_flag) |=> !idle_flag);

  assert_hold_in_sby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !wake_sel) |-> !deliver);

  assert_deliver_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |-> char_done);
endmodule

// File: tb/tb_rx_standby_wake.sv
module tb_rx_standby_wake;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, line_in = 1, char_done = 0, addr_mark = 0;
  logic wake_sel = 0, idle_type = 0, idle_in_sby = 0, idle_ie = 0;
  logic nine_bit = 0, two_stop = 0, sby_set = 0, sby_clr = 0, idle_clr = 0;
  logic idle_flag, idle_irq, standby, deliver, wake;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int m_run = 0;
  bit m_armed = 1, m_flag = 0, m_sby = 0;

  always #5 clk = ~clk;

  rx_standby_wake dut (.*);

  function automatic int flen();
    return 10 + int'(nine_bit) + int'(two_stop);
  endfunction

  function automatic bit m_evt();
    return bit_tick && line_in && !(idle_type && char_done) && (m_run == flen() - 1);
  endfunction

  task automatic cmp(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    cmp("R2/R4/R5/R10 idle_flag", idle_flag, m_flag);
    cmp("R6 idle_irq", idle_irq, m_flag && idle_ie);
    cmp("R7 standby", standby, m_sby);
    cmp("R8/R9/R11 deliver", deliver, char_done && (!m_sby || (wake_sel && addr_mark)));
    cmp("R8/R9 wake", wake, m_sby && (wake_sel ? (char_done && addr_mark) : m_evt()));
  end

  always @(posedge clk) if (rst_n) begin
    bit ev, st, wk;
    ev = m_evt();
    st = ev && m_armed && (!m_sby || idle_in_sby);
    wk = m_sby && (wake_sel ? (char_done && addr_mark) : ev);
    if (idle_type && char_done) m_run = 0;
    else if (bit_tick) m_run = line_in ? ((m_run < flen()) ? m_run + 1 : m_run) : 0;
    if (st) m_flag = 1; else if (idle_clr) m_flag = 0;
    if (char_done) m_armed = 1; else if (st) m_armed = 0;
    if (sby_set) m_sby = 1; else if (sby_clr || wk) m_sby = 0;
  end

  task automatic tk(logic lv, logic dn = 0, logic mk = 0);
    @(posedge clk); #1;
    bit_tick = 1; line_in = lv; char_done = dn; addr_mark = mk;
    @(posedge clk); #1;
    bit_tick = 0; char_done = 0; addr_mark = 0;
    @(posedge clk); #1;
  endtask

  task automatic pulse(string which);
    @(posedge clk); #1;
    if (which == "set") sby_set = 1;
    if (which == "clr") sby_clr = 1;
    if (which == "iclr") idle_clr = 1;
    @(posedge clk); #1;
    sby_set = 0; sby_clr = 0; idle_clr = 0;
  endtask

  task automatic highs(int n);
    for (int i = 0; i < n; i++) tk(1);
  endtask

  task automatic frame(logic [7:0] d, logic mk);
    tk(0);
    for (int i = 0; i < 8; i++) tk(d[i]);
    if (nine_bit) tk(mk);
    if (two_stop) tk(1);
    tk(1, 1, nine_bit ? mk : d[7]);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    cmp("R1 idle_flag", idle_flag, 0);
    cmp("R1 standby", standby, 0);
    cmp("R1 idle_irq", idle_irq, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle_ie = 1;
    // R2: a full run of high ticks sets the flag; R6 irq follows
    highs(12);
    // R4: flag not set again without a character; R5 clear
    pulse("iclr");
    highs(12);
    // R3 idle_type 0: high data and stop bits count toward the run
    frame(8'hF0, 0);
    highs(6);
    pulse("iclr");
    // R3 idle_type 1: count only after the stop bit
    idle_type = 1;
    frame(8'hF0, 0);
    highs(11);
    pulse("iclr");
    // R2 longer frames: 9-bit and two stop bits
    nine_bit = 1; two_stop = 1;
    frame(8'h3C, 1);
    highs(13);
    pulse("iclr");
    nine_bit = 0; two_stop = 0; idle_type = 0;
    // R4 collision: run completes on the char_done tick
    tk(0); highs(9); tk(1, 1, 0);
    pulse("iclr"); highs(11);
    pulse("iclr");
    idle_type = 1;
    tk(0); highs(9); tk(1, 1, 0);
    highs(11);
    pulse("iclr");
    idle_type = 0;
    // R8 idle-line wakeup, R10 flag withheld in standby
    wake_sel = 0; idle_in_sby = 0;
    pulse("set");
    frame(8'h55, 0);
    frame(8'h12, 0);
    highs(11);
    frame(8'h34, 0);
    // R10 flag allowed in standby
    idle_in_sby = 1;
    pulse("set");
    frame(8'h66, 0);
    highs(11);
    pulse("iclr");
    // R9 address-mark wakeup, idle does not wake
    wake_sel = 1;
    pulse("set");
    frame(8'h01, 0);
    highs(12);
    frame(8'h81, 1);
    frame(8'h02, 0);
    // R9 in 9-bit mode the ninth bit is the mark
    nine_bit = 1;
    pulse("set");
    frame(8'hFF, 0);
    frame(8'h10, 1);
    nine_bit = 0;
    // R7 sby_set wins over a wake in the same cycle, and over sby_clr
    pulse("set");
    tk(0); highs(8);
    @(posedge clk); #1;
    bit_tick = 1; line_in = 1; char_done = 1; addr_mark = 1; sby_set = 1;
    @(posedge clk); #1;
    bit_tick = 0; char_done = 0; addr_mark = 0; sby_set = 0;
    @(posedge clk); #1 sby_set = 1; sby_clr = 1;
    @(posedge clk); #1 sby_set = 0; sby_clr = 0;
    pulse("clr");
    // R11 deliver only with char_done outside standby
    frame(8'hA5, 1);
    idle_ie = 0;
    highs(12);
    repeat (4) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule